// File: doc/BRIEF.md
# Packed SIMD Saturating Add/Subtract Unit

This unit treats a 32-bit word as a set of independent lanes, either four bytes or two halfwords, and applies one lane-wise operation to a pair of operands per strobe. The operations are add, subtract, halving add and halving subtract (with optional rounding), shift left, logical shift right, arithmetic shift right (with optional rounding) and absolute value. A sign select sets how lanes are read, and a combined saturate/round select sets whether out-of-range lanes clamp or wrap, or whether halving and arithmetic shifts round.

Overflow is reported by OR-ing flag bits into a 32-bit control word that is passed in with the operands and handed back with the result. Add, subtract and absolute-value overflow share one flag, and left-shift overflow has its own. The unit never clears a flag, so a caller that writes the returned word back gets sticky overflow status. The result and the updated control word are registered and appear one clock after the input strobe, marked by a one-cycle valid pulse.

Top module: `simd_lane_alu`

## Requirements
- R1: With `lane_half` = 0 the word holds four 8-bit lanes, lane i in bits [8i+7:8i]; with `lane_half` = 1 it holds two 16-bit lanes, lane i in bits [16i+15:16i]. Lanes never carry into each other.
- R2: Opcode 0 adds and opcode 1 subtracts lane-wise. Lanes are sign-extended when `is_signed` = 1 and zero-extended otherwise. With `sat_rnd` = 0 the low lane bits of the exact result are kept, and a lane outside the format range still sets control bit 20.
- R3: With `sat_rnd` = 1, an add or subtract lane above the format maximum (127/32767 signed, 255/65535 unsigned) returns the maximum, and one below the minimum (-128/-32768 signed, 0 unsigned) returns the minimum. Either clamp sets control bit 20.
- R4: Opcode 2 returns (a+b)>>1 and opcode 3 returns (a-b)>>1 per lane, computed at full precision with an arithmetic shift. With `sat_rnd` = 1, 1 is added before the shift. These opcodes never set a flag.
- R5: Opcode 4 shifts each lane left by `shamt` masked to its low 3 bits (byte lanes) or 4 bits (halfword lanes). It wraps or saturates under `sat_rnd` as in R2 and R3. An out-of-range lane sets control bit 22 and not bit 20. No other opcode sets bit 22.
- R6: Opcode 5 shifts lanes right logically, reading them as unsigned whatever `is_signed` says. Opcode 6 shifts right arithmetically, reading them as signed. With `sat_rnd` = 1 and a nonzero masked amount s, opcode 6 adds 1<<(s-1) before the shift. Neither opcode sets a flag.
- R7: Opcode 7 returns the absolute value of each lane, always read as signed. The most negative lane value returns the most positive value and sets control bit 20.
- R8: `ctrl_out` equals `ctrl_in` with bits 20 and 22 set where R2–R7 call for it. No bit of `ctrl_in` is ever cleared.
- R9: `result`, `ctrl_out` and a one-cycle `out_valid` pulse appear on the clock edge after the edge that samples `in_valid` = 1. Strobes may be back to back. Without a strobe, `out_valid` is 0 and `result` and `ctrl_out` hold.
- R10: While `rst_n` is low, `out_valid`, `result` and `ctrl_out` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Operand strobe |
| opcode | input | 3 | Operation select (0..7, see R2–R7) |
| lane_half | input | 1 | 0: four byte lanes, 1: two halfword lanes |
| is_signed | input | 1 | Signed lane interpretation |
| sat_rnd | input | 1 | Saturate (add/sub/shift left) or round (halving, arithmetic right) |
| shamt | input | 4 | Shift amount before lane masking |
| op_a | input | 32 | First packed operand |
| op_b | input | 32 | Second packed operand |
| ctrl_in | input | 32 | Control word to be updated |
| out_valid | output | 1 | Result strobe |
| result | output | 32 | Packed lane result |
| ctrl_out | output | 32 | Control word with overflow flags OR-ed in |

## Verification
Every result and its control word are due exactly one clock after the edge that takes the strobe. The driver changes inputs on falling edges and pushes the expected pair into a queue as it drives. The monitor wakes 1 ns after each rising edge, and whenever `out_valid` is high it pops the oldest entry and compares it. A missing, extra or late output therefore shows up as a mismatch or as a leftover queue entry. Once the stream stops, idle cycles confirm that `out_valid` stays low and that the last result holds.

// File: rtl/simd_alu_pkg.sv
package simd_alu_pkg;

   localparam int SHAMT_W = 4;
   localparam int CTRL_W  = 32;

   typedef enum logic [2:0] {
      OP_ADD  = 3'd0,
      OP_SUB  = 3'd1,
      OP_HADD = 3'd2,
      OP_HSUB = 3'd3,
      OP_SHL  = 3'd4,
      OP_SHRL = 3'd5,
      OP_SHRA = 3'd6,
      OP_ABS  = 3'd7
   } lane_op_e;

endpackage

// File: rtl/simd_lane_op.sv
module simd_lane_op
   import simd_alu_pkg::*;
#(
   parameter int LW = 8
) (
   input  lane_op_e             op,
   input  logic                 is_signed,
   input  logic                 sat_rnd,
   input  logic [SHAMT_W-1:0]   shamt,
   input  logic [LW-1:0]        a,
   input  logic [LW-1:0]        b,
   output logic [LW-1:0]        res,
   output logic                 ovf_arith,
   output logic                 ovf_shl
);
   localparam int SAW = $clog2(LW);
   localparam int XW  = 2*LW + 2;
   localparam logic signed [XW-1:0] S_MAX = XW'((1 << (LW-1)) - 1);
   localparam logic signed [XW-1:0] S_MIN = -S_MAX - XW'(1);
   localparam logic signed [XW-1:0] U_MAX = XW'((1 << LW) - 1);
   localparam logic signed [XW-1:0] ZERO  = '0;

   logic [SAW-1:0]          sa;
   logic signed [XW-1:0]    a_sx, b_sx, a_zx, b_zx, ax, bx;
   logic signed [XW-1:0]    lim_hi, lim_lo, wide, rnd;
   logic                    clampable, above, below;

   always_comb begin
      sa     = SAW'(shamt);
      a_sx   = {{(XW-LW){a[LW-1]}}, a};
      b_sx   = {{(XW-LW){b[LW-1]}}, b};
      a_zx   = {{(XW-LW){1'b0}}, a};
      b_zx   = {{(XW-LW){1'b0}}, b};
      ax     = is_signed ? a_sx : a_zx;
      bx     = is_signed ? b_sx : b_zx;
      lim_hi = is_signed ? S_MAX : U_MAX;
      lim_lo = is_signed ? S_MIN : ZERO;
      rnd    = (sat_rnd && sa != '0) ? (XW'(1) << (sa - SAW'(1))) : ZERO;

      wide      = ZERO;
      clampable = 1'b0;
      res       = '0;
      ovf_arith = 1'b0;
      ovf_shl   = 1'b0;

      unique case (op)
         OP_ADD:  begin wide = ax + bx;  clampable = 1'b1; end
         OP_SUB:  begin wide = ax - bx;  clampable = 1'b1; end
         OP_SHL:  begin wide = ax <<< sa; clampable = 1'b1; end
         OP_HADD: begin
            wide = (ax + bx + XW'(sat_rnd)) >>> 1;
            res  = wide[LW-1:0];
         end
         OP_HSUB: begin
            wide = (ax - bx + XW'(sat_rnd)) >>> 1;
            res  = wide[LW-1:0];
         end
         OP_SHRL: res = a >> sa;
         OP_SHRA: begin
            wide = (a_sx + rnd) >>> sa;
            res  = wide[LW-1:0];
         end
         OP_ABS: begin
            if (a_sx == S_MIN) begin
               res       = S_MAX[LW-1:0];
               ovf_arith = 1'b1;
            end else if (a[LW-1]) begin
               res = LW'(-a_sx);
            end else begin
               res = a;
            end
         end
         default: res = '0;
      endcase

      above = wide > lim_hi;
      below = wide < lim_lo;
      if (clampable) begin
         if (sat_rnd && above)      res = lim_hi[LW-1:0];
         else if (sat_rnd && below) res = lim_lo[LW-1:0];
         else                       res = wide[LW-1:0];
         if (op == OP_SHL) ovf_shl   = above || below;
         else              ovf_arith = above || below;
      end
   end

endmodule

// File: rtl/simd_lane_array.sv
module simd_lane_array
   import simd_alu_pkg::*;
#(
   parameter int DATA_W = 32,
   parameter int LW     = 8
) (
   input  lane_op_e             op,
   input  logic                 is_signed,
   input  logic                 sat_rnd,
   input  logic [SHAMT_W-1:0]   shamt,
   input  logic [DATA_W-1:0]    a,
   input  logic [DATA_W-1:0]    b,
   output logic [DATA_W-1:0]    res,
   output logic                 ovf_arith,
   output logic                 ovf_shl
);
   localparam int N = DATA_W / LW;

   logic [N-1:0] lane_ovf_a, lane_ovf_s;

   for (genvar i = 0; i < N; i++) begin : g_lane
      simd_lane_op #(.LW(LW)) u_lane (
         .op        (op),
         .is_signed (is_signed),
         .sat_rnd   (sat_rnd),
         .shamt     (shamt),
         .a         (a[i*LW +: LW]),
         .b         (b[i*LW +: LW]),
         .res       (res[i*LW +: LW]),
         .ovf_arith (lane_ovf_a[i]),
         .ovf_shl   (lane_ovf_s[i])
      );
   end

   assign ovf_arith = |lane_ovf_a;
   assign ovf_shl   = |lane_ovf_s;

endmodule

// File: rtl/simd_lane_alu.sv
module simd_lane_alu
   import simd_alu_pkg::*;
#(
   parameter int DATA_W         = 32,
   parameter int ARITH_FLAG_BIT = 20,
   parameter int SHIFT_FLAG_BIT = 22
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 in_valid,
   input  logic [2:0]           opcode,
   input  logic                 lane_half,
   input  logic                 is_signed,
   input  logic                 sat_rnd,
   input  logic [SHAMT_W-1:0]   shamt,
   input  logic [DATA_W-1:0]    op_a,
   input  logic [DATA_W-1:0]    op_b,
   input  logic [CTRL_W-1:0]    ctrl_in,
   output logic                 out_valid,
   output logic [DATA_W-1:0]    result,
   output logic [CTRL_W-1:0]    ctrl_out
);
   localparam int BYTE_W = 8;
   localparam int HALF_W = 16;

   if (DATA_W < HALF_W || DATA_W % HALF_W != 0) begin : g_bad_width
      $error("simd_lane_alu: DATA_W must be a positive multiple of 16");
   end
   if (ARITH_FLAG_BIT >= CTRL_W || SHIFT_FLAG_BIT >= CTRL_W ||
       ARITH_FLAG_BIT == SHIFT_FLAG_BIT) begin : g_bad_flag
      $error("simd_lane_alu: flag bits must be distinct and inside the control word");
   end

   lane_op_e            op;
   logic [DATA_W-1:0]   byte_res, half_res, res_nxt;
   logic                byte_ovf_a, byte_ovf_s, half_ovf_a, half_ovf_s;
   logic [CTRL_W-1:0]   ctrl_nxt;

   assign op = lane_op_e'(opcode);

   simd_lane_array #(.DATA_W(DATA_W), .LW(BYTE_W)) u_bytes (
      .op        (op),
      .is_signed (is_signed),
      .sat_rnd   (sat_rnd),
      .shamt     (shamt),
      .a         (op_a),
      .b         (op_b),
      .res       (byte_res),
      .ovf_arith (byte_ovf_a),
      .ovf_shl   (byte_ovf_s)
   );

   simd_lane_array #(.DATA_W(DATA_W), .LW(HALF_W)) u_halves (
      .op        (op),
      .is_signed (is_signed),
      .sat_rnd   (sat_rnd),
      .shamt     (shamt),
      .a         (op_a),
      .b         (op_b),
      .res       (half_res),
      .ovf_arith (half_ovf_a),
      .ovf_shl   (half_ovf_s)
   );

   always_comb begin
      res_nxt  = lane_half ? half_res : byte_res;
      ctrl_nxt = ctrl_in;
      if (lane_half ? half_ovf_a : byte_ovf_a) ctrl_nxt[ARITH_FLAG_BIT] = 1'b1;
      if (lane_half ? half_ovf_s : byte_ovf_s) ctrl_nxt[SHIFT_FLAG_BIT] = 1'b1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_valid <= 1'b0;
         result    <= '0;
         ctrl_out  <= '0;
      end else begin
         out_valid <= in_valid;
         if (in_valid) begin
            result   <= res_nxt;
            ctrl_out <= ctrl_nxt;
         end
      end
   end

endmodule

// File: rtl/simd_lane_alu_chk.sv
module simd_lane_alu_chk
   import simd_alu_pkg::*;
#(
   parameter int DATA_W         = 32,
   parameter int ARITH_FLAG_BIT = 20,
   parameter int SHIFT_FLAG_BIT = 22
) (
   input logic                 clk,
   input logic                 rst_n,
   input logic                 in_valid,
   input logic [2:0]           opcode,
   input logic [CTRL_W-1:0]    ctrl_in,
   input logic                 out_valid,
   input logic [DATA_W-1:0]    result,
   input logic [CTRL_W-1:0]    ctrl_out
);
   localparam logic [CTRL_W-1:0] FLAG_MASK =
      (CTRL_W'(1) << ARITH_FLAG_BIT) | (CTRL_W'(1) << SHIFT_FLAG_BIT);

   assert_valid_follows_R9: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> out_valid);

   assert_valid_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> !out_valid);

   assert_hold_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> ($stable(result) && $stable(ctrl_out)));

   assert_sticky_flags_R8: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> ((ctrl_out & $past(ctrl_in)) == $past(ctrl_in)));

   assert_other_bits_pass_R8: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> ((ctrl_out & ~FLAG_MASK) == ($past(ctrl_in) & ~FLAG_MASK)));

   assert_halving_no_flag_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && (opcode == 3'd2 || opcode == 3'd3)) |=> (ctrl_out == $past(ctrl_in)));

   assert_shift_flag_only_shl_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && opcode != 3'd4) |=>
         (ctrl_out[SHIFT_FLAG_BIT] == $past(ctrl_in[SHIFT_FLAG_BIT])));

   assert_shl_no_arith_flag_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && opcode == 3'd4) |=>
         (ctrl_out[ARITH_FLAG_BIT] == $past(ctrl_in[ARITH_FLAG_BIT])));

   assert_right_shift_no_flag_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && (opcode == 3'd5 || opcode == 3'd6)) |=> (ctrl_out == $past(ctrl_in)));

endmodule

bind simd_lane_alu simd_lane_alu_chk #(
   .DATA_W         (DATA_W),
   .ARITH_FLAG_BIT (ARITH_FLAG_BIT),
   .SHIFT_FLAG_BIT (SHIFT_FLAG_BIT)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .in_valid  (in_valid),
   .opcode    (opcode),
   .ctrl_in   (ctrl_in),
   .out_valid (out_valid),
   .result    (result),
   .ctrl_out  (ctrl_out)
);

// File: tb/simd_lane_alu_tb.sv
`timescale 1ns/1ps
module simd_lane_alu_tb;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        in_valid = 1'b0;
   logic [2:0]  opcode = '0;
   logic        lane_half = 1'b0;
   logic        is_signed = 1'b0;
   logic        sat_rnd = 1'b0;
   logic [3:0]  shamt = '0;
   logic [31:0] op_a = '0, op_b = '0, ctrl_in = '0;
   logic        out_valid;
   logic [31:0] result, ctrl_out;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;
   logic [31:0] last_res = '0, last_ctrl = '0;

   typedef struct {
      logic [31:0] res;
      logic [31:0] ctrl;
      string       tag;
   } exp_t;
   exp_t sb[$];

   always #2 clk = ~clk;

   simd_lane_alu u_dut (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .opcode(opcode),
      .lane_half(lane_half), .is_signed(is_signed), .sat_rnd(sat_rnd),
      .shamt(shamt), .op_a(op_a), .op_b(op_b), .ctrl_in(ctrl_in),
      .out_valid(out_valid), .result(result), .ctrl_out(ctrl_out)
   );

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   // Independent lane model written from the requirements.
   function automatic void ref_word(input int op, input bit fh, input bit sg, input bit sr,
                                    input int sh, input logic [31:0] a, input logic [31:0] b,
                                    input logic [31:0] ci, output logic [31:0] r,
                                    output logic [31:0] c);
      int lw, n, s;
      longint m, av, bv, as, w, hi, lo, lv;
      bit fa, fs;
      lw = fh ? 16 : 8;
      n  = 32 / lw;
      m  = (longint'(1) << lw) - 1;
      s  = sh & (lw - 1);
      hi = sg ? (longint'(1) << (lw-1)) - 1 : m;
      lo = sg ? -(longint'(1) << (lw-1)) : 0;
      fa = 0; fs = 0; r = '0;
      for (int i = 0; i < n; i++) begin
         av = (longint'(a) >> (i*lw)) & m;
         bv = (longint'(b) >> (i*lw)) & m;
         as = av;
         if (av >= (longint'(1) << (lw-1))) as = av - (longint'(1) << lw);
         if (sg) begin
            if (bv >= (longint'(1) << (lw-1))) bv = bv - (longint'(1) << lw);
            av = as;
         end
         lv = 0;
         case (op)
            0, 1, 4: begin
               w = (op == 0) ? av + bv : (op == 1) ? av - bv : av * (longint'(1) << s);
               if (w > hi || w < lo) begin
                  if (op == 4) fs = 1; else fa = 1;
               end
               if (sr && w > hi) lv = hi;
               else if (sr && w < lo) lv = lo;
               else lv = w;
            end
            2: lv = (av + bv + longint'(sr)) >>> 1;
            3: lv = (av - bv + longint'(sr)) >>> 1;
            5: lv = (((longint'(a) >> (i*lw)) & m) >> s);
            6: begin
               w = as + ((sr && s > 0) ? (longint'(1) << (s-1)) : 0);
               lv = w >>> s;
            end
            default: begin
               if (as == -(longint'(1) << (lw-1))) begin
                  lv = (longint'(1) << (lw-1)) - 1; fa = 1;
               end else lv = (as < 0) ? -as : as;
            end
         endcase
         r = r | 32'((lv & m) << (i*lw));
      end
      c = ci;
      if (fa) c[20] = 1'b1;
      if (fs) c[22] = 1'b1;
   endfunction

   task automatic send(input int op, input bit fh, input bit sg, input bit sr, input int sh,
                       input logic [31:0] a, input logic [31:0] b, input logic [31:0] ci,
                       input logic [31:0] er, input logic [31:0] ec, input string tag);
      @(negedge clk);
      in_valid  = 1'b1;
      opcode    = op[2:0];
      lane_half = fh;
      is_signed = sg;
      sat_rnd   = sr;
      shamt     = sh[3:0];
      op_a = a; op_b = b; ctrl_in = ci;
      sb.push_back('{res: er, ctrl: ec, tag: tag});
      last_res = er; last_ctrl = ec;
   endtask

   task automatic send_ref(input int op, input bit fh, input bit sg, input bit sr, input int sh,
                           input logic [31:0] a, input logic [31:0] b, input logic [31:0] ci,
                           input string tag);
      logic [31:0] er, ec;
      ref_word(op, fh, sg, sr, sh, a, b, ci, er, ec);
      send(op, fh, sg, sr, sh, a, b, ci, er, ec, tag);
   endtask

   // Monitor: results are due one edge after the strobe; sample 1 ns past each edge.
   initial begin
      forever begin
         @(posedge clk);
         #1;
         if (rst_n && out_valid) begin
            if (sb.size() == 0) begin
               checks++; errors++;
               $display("FAIL R9: unexpected out_valid, result %h expected none", result);
            end else begin
               exp_t e;
               e = sb.pop_front();
               check({e.tag, " result"}, result, e.res);
               check({e.tag, " ctrl"}, ctrl_out, e.ctrl);
            end
         end
      end
   end

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
   end

   initial begin
      repeat (3) @(posedge clk);
      #1;
      check("R10 reset out_valid", {31'd0, out_valid}, 32'd0);
      check("R10 reset result", result, 32'd0);
      check("R10 reset ctrl", ctrl_out, 32'd0);
      @(negedge clk);
      rst_n = 1'b1;

      // R2 wrap, signed bytes: overflowing lanes wrap but still flag bit 20
      send(0, 0, 1, 0, 0, 32'h7F01_8010, 32'h0101_FF10, 32'h0, 32'h8002_7F20, 32'h0010_0000, "R2 add wrap");
      // R3 saturate, signed bytes
      send(0, 0, 1, 1, 0, 32'h7F01_8010, 32'h0101_FF10, 32'h0, 32'h7F02_8020, 32'h0010_0000, "R3 add sat signed");
      // R3 saturate, unsigned byte subtract clamps at zero
      send(1, 0, 0, 1, 0, 32'h10FF_0005, 32'h2001_0105, 32'h0, 32'h00FE_0000, 32'h0010_0000, "R3 sub sat unsigned");
      // R1 halfword lanes, unsigned saturate
      send(0, 1, 0, 1, 0, 32'hFFFF_0001, 32'h0001_0002, 32'h0, 32'hFFFF_0003, 32'h0010_0000, "R1 half add sat");
      // R4 halving add with and without rounding, no flag even at extremes
      send(2, 0, 1, 1, 0, 32'h037F_80FF, 32'h007F_8000, 32'h0, 32'h027F_8000, 32'h0, "R4 hadd round");
      send(2, 0, 1, 0, 0, 32'h037F_80FF, 32'h007F_8000, 32'h0, 32'h017F_80FF, 32'h0, "R4 hadd trunc");
      // R5 shift amount 9 masked to 1 for bytes, saturate, sticky with bit 20 already set (R8)
      send(4, 0, 1, 1, 9, 32'h4001_C081, 32'h0, 32'h0010_0000, 32'h7F02_8080, 32'h0050_0000, "R5 shl sat mask");
      // R5 halfword shift left wraps, flags bit 22
      send(4, 1, 0, 0, 4, 32'h1234_0F00, 32'h0, 32'h0, 32'h2340_F000, 32'h0040_0000, "R5 half shl wrap");
      // R6 logical right ignores sign select
      send(5, 0, 1, 0, 3, 32'h80FF_1007, 32'h0, 32'h0, 32'h101F_0200, 32'h0, "R6 shrl");
      // R6 arithmetic right with and without rounding
      send(6, 0, 0, 1, 2, 32'h8006_FE7F, 32'h0, 32'h0, 32'hE002_0020, 32'h0, "R6 shra round");
      send(6, 0, 0, 0, 2, 32'h8006_FE7F, 32'h0, 32'h0, 32'hE001_FF1F, 32'h0, "R6 shra trunc");
      // R7 absolute value of the most negative halfword
      send(7, 1, 0, 0, 0, 32'h8000_FFFB, 32'h0, 32'h0, 32'h7FFF_0005, 32'h0010_0000, "R7 abs half");
      send(7, 0, 0, 0, 0, 32'h8001_7FFE, 32'h0, 32'h0040_0000, 32'h7F01_7F02, 32'h0050_0000, "R7 abs byte sticky");
      // R8 no flag cleared, all ones in
      send(0, 0, 0, 0, 0, 32'h0102_0304, 32'h0101_0101, 32'hFFFF_FFFF, 32'h0203_0405, 32'hFFFF_FFFF, "R8 pass through");

      for (int k = 0; k < 80; k++) begin
         send_ref(int'($urandom % 8), bit'($urandom % 2), bit'($urandom % 2), bit'($urandom % 2),
                  int'($urandom % 16), $urandom, $urandom, $urandom & 32'hFF0F_FFFF, "R2 R5 model");
      end

      @(negedge clk);
      in_valid = 1'b0;
      repeat (4) @(posedge clk);
      #1;
      check("R9 idle out_valid", {31'd0, out_valid}, 32'd0);
      check("R9 hold result", result, last_res);
      check("R9 hold ctrl", ctrl_out, last_ctrl);
      check("R9 queue drained", sb.size(), 0);
      finish_run();
   end

endmodule